// File: doc/BRIEF.md
# Branch Unit with Single-Entry Jump Cache

This block sits at the front of a four-stage fetch, decode, execute and write-back pipeline. It owns the fetch address, hands each fetched word on to decode, and reacts when execute reports a resolved branch. The instruction word that is in fetch during a redirect is not used. A taken branch normally costs one machine cycle: a no-operation bubble goes into decode while the target word is being fetched. A not-taken branch costs nothing, and the sequential flow simply continues.

To remove the bubble from tight loops, the block keeps one cache entry. The entry records a branch address, that branch's target, and the opcode found at the target. The entry is filled on a taken branch that misses. The opcode is captured one cycle later, when the target word arrives from memory. When the same branch at the same target is taken again, the cached opcode goes straight into decode and fetch moves on to the word after the target. The loop branch then costs no cycle. An interrupt reuses the same bubble path to redirect fetch to its vector, and it never reads or fills the cache. A write to instruction memory clears the entry, so a stale opcode can never be replayed.

Top module: `branch_jump_cache`

## Requirements
- R1: While reset is asserted and in the first cycle after it, fetch_addr equals RESET_ADDR and dec_instr is all zeros. Reset leaves the cache empty, so the first taken branch always misses.
- R2: In a cycle with no taken branch and no interrupt, dec_instr takes the current fetch_instr at the next clock edge, and fetch_addr advances by one.
- R3: A branch reported with br_valid=1 and br_taken=0 behaves exactly as R2, so no cycle is lost.
- R4: A taken branch (br_valid=1, br_taken=1) that misses puts the all-zero no-operation into dec_instr at the next edge and sets fetch_addr to br_target.
- R5: A missing taken branch loads the entry with br_addr and br_target and marks it valid. The entry's opcode is the fetch_instr seen in the following cycle, which is the word at the target.
- R6: A taken branch hits when the entry is valid, its opcode has been captured, and both br_addr and br_target match the entry. On a hit, dec_instr takes the cached opcode at the next edge and fetch_addr becomes br_target plus one.
- R7: A taken branch whose address or target differs from the entry misses as in R4 and replaces the entry.
- R8: imem_wr=1 empties the cache at the next edge. This takes priority over a fill in the same cycle, so a following taken branch misses. After refilling, the hit returns the new memory contents.
- R9: irq_take=1 puts the no-operation into decode and sets fetch_addr to irq_vector. It overrides any branch reported in the same cycle, and it neither uses nor changes the cache entry.
- R10: A taken branch in the cycle directly after a fill, before the opcode has been captured, is treated as a miss, even when it matches the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| br_valid | input | 1 | Execute is resolving a branch this cycle |
| br_taken | input | 1 | The resolved branch is taken |
| br_addr | input | AW | Address of the resolving branch |
| br_target | input | AW | Target address of the resolving branch |
| irq_take | input | 1 | Redirect fetch to an interrupt vector |
| irq_vector | input | AW | Service routine address |
| imem_wr | input | 1 | Instruction memory is being written |
| fetch_instr | input | IW | Word read at fetch_addr this cycle |
| fetch_addr | output | AW | Current fetch address |
| dec_instr | output | IW | Instruction presented to decode |

## Verification
The bench runs a reference model alongside the design and compares fetch_addr and dec_instr after every edge. It drives the following patterns:
- Straight-line flow and not-taken branches, which show whether any cycle is lost when nothing is taken.
- A loop branch repeated several times, which separates the first-pass bubble from the zero-cost hits.
- Alternating branches, and one branch address with two targets, which show that the entry is replaced and that the key covers both fields.
- Memory writes, a branch taken right after a fill, and interrupts that collide with hit-ready branches, which expose stale replays, premature hits and cache pollution by vectoring.

// File: rtl/branch_jump_cache.sv
module branch_jump_cache #(
  parameter int AW = 16,
  parameter int IW = 16,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          br_valid,
  input  logic          br_taken,
  input  logic [AW-1:0] br_addr,
  input  logic [AW-1:0] br_target,
  input  logic          irq_take,
  input  logic [AW-1:0] irq_vector,
  input  logic          imem_wr,
  input  logic [IW-1:0] fetch_instr,
  output logic [AW-1:0] fetch_addr,
  output logic [IW-1:0] dec_instr
);
  localparam logic [AW-1:0] STEP = AW'(1);
  localparam logic [IW-1:0] BUBBLE = '0;

  logic [AW-1:0] pc, c_tag, c_tgt;
  logic [IW-1:0] c_op, dec_q;
  logic          c_vld, fill_pend;

  wire taken = br_valid & br_taken;
  wire hit   = taken & c_vld & ~fill_pend & (c_tag == br_addr) & (c_tgt == br_target);

  assign fetch_addr = pc;
  assign dec_instr  = dec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc        <= RESET_ADDR;
      dec_q     <= BUBBLE;
      c_vld     <= 1'b0;
      fill_pend <= 1'b0;
      c_tag     <= '0;
      c_tgt     <= '0;
      c_op      <= '0;
    end else begin
      fill_pend <= 1'b0;
      if (fill_pend) c_op <= fetch_instr;
      if (irq_take) begin
        pc    <= irq_vector;
        dec_q <= BUBBLE;
      end else if (hit) begin
        pc    <= br_target + STEP;
        dec_q <= c_op;
      end else if (taken) begin
        pc        <= br_target;
        dec_q     <= BUBBLE;
        c_tag     <= br_addr;
        c_tgt     <= br_target;
        c_vld     <= 1'b1;
        fill_pend <= 1'b1;
      end else begin
        pc    <= pc + STEP;
        dec_q <= fetch_instr;
      end
      if (imem_wr) begin
        c_vld     <= 1'b0;
        fill_pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/branch_jump_cache_chk.sv
module branch_jump_cache_chk #(
  parameter int AW = 16,
  parameter int IW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          br_valid,
  input logic          br_taken,
  input logic [AW-1:0] br_addr,
  input logic [AW-1:0] br_target,
  input logic          irq_take,
  input logic [AW-1:0] irq_vector,
  input logic          imem_wr,
  input logic [IW-1:0] fetch_instr,
  input logic [AW-1:0] fetch_addr,
  input logic [IW-1:0] dec_instr,
  input logic          c_vld,
  input logic [AW-1:0] c_tag,
  input logic [AW-1:0] c_tgt,
  input logic          fill_pend
);
  wire tk  = br_valid & br_taken;
  wire mat = c_vld & ~fill_pend & (c_tag == br_addr) & (c_tgt == br_target);

  a_r2_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_take && !tk) |=> (dec_instr == $past(fetch_instr)) && (fetch_addr == $past(fetch_addr) + AW'(1)));

  a_r4_miss_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_take && tk && !mat) |=> (dec_instr == '0) && (fetch_addr == $past(br_target)));

  a_r6_hit_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_take && tk && mat) |=> (fetch_addr == $past(br_target) + AW'(1)));

  a_r8_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    imem_wr |=> !c_vld);

  a_r9_irq_vector: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> (dec_instr == '0) && (fetch_addr == $past(irq_vector)));

  a_r9_irq_cache_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && !imem_wr) |=> $stable(c_tag) && $stable(c_tgt));

  a_r10_no_early_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_take && tk && fill_pend) |=> (dec_instr == '0));
endmodule

bind branch_jump_cache branch_jump_cache_chk #(.AW(AW), .IW(IW)) u_chk (.*);

// File: tb/branch_jump_cache_tb.sv
module branch_jump_cache_tb;
  localparam int AW = 16;
  localparam int IW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          br_valid = 1'b0, br_taken = 1'b0, irq_take = 1'b0, imem_wr = 1'b0;
  logic [AW-1:0] br_addr = '0, br_target = '0, irq_vector = '0;
  logic [IW-1:0] fetch_instr;
  logic [AW-1:0] fetch_addr;
  logic [IW-1:0] dec_instr;

  always #10 clk = ~clk;

  int    checks = 0;
  int    fails = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  int gen = 0;
  function automatic logic [IW-1:0] memw(input logic [AW-1:0] a, input int g);
    return {a[7:0] ^ 8'(g * 37 + 5), 8'h80 | a[7:0]};
  endfunction

  assign fetch_instr = memw(fetch_addr, gen);

  branch_jump_cache #(.AW(AW), .IW(IW)) u_dut (.*);

  // reference model
  int            m_pc = 0;
  logic [IW-1:0] m_dec = '0;
  bit            m_have = 0, m_wait = 0;
  int            m_from = 0, m_to = 0;
  logic [IW-1:0] m_word = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc <= 0; m_dec <= '0; m_have <= 0; m_wait <= 0; gen <= 0;
    end else begin
      automatic bit t = br_valid && br_taken;
      automatic bit h = t && m_have && !m_wait && (m_from == int'(br_addr)) && (m_to == int'(br_target));
      automatic bit nw = 0;
      if (m_wait) m_word <= memw(16'(m_pc), gen);
      if (irq_take) begin m_pc <= int'(irq_vector); m_dec <= '0; end
      else if (h) begin m_pc <= (int'(br_target) + 1) % 65536; m_dec <= m_word; end
      else if (t) begin
        m_pc <= int'(br_target); m_dec <= '0;
        m_from <= int'(br_addr); m_to <= int'(br_target);
        m_have <= 1; nw = 1;
      end else begin m_pc <= (m_pc + 1) % 65536; m_dec <= memw(16'(m_pc), gen); end
      m_wait <= nw && !imem_wr;
      if (imem_wr) begin m_have <= 0; gen <= gen + 1; end
    end
  end

  task automatic check_now();
    checks++;
    if (int'(fetch_addr) != m_pc) begin
      fails++;
      $display("FAIL %s fetch_addr actual %h expected %h", cur_req, fetch_addr, 16'(m_pc));
    end
    checks++;
    if (dec_instr !== m_dec) begin
      fails++;
      $display("FAIL %s dec_instr actual %h expected %h", cur_req, dec_instr, m_dec);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) check_now();

  task automatic step(input bit bv, input bit bt, input int ba, input int bg,
                      input bit iq, input int iv, input bit wr);
    br_valid = bv; br_taken = bt; br_addr = 16'(ba); br_target = 16'(bg);
    irq_take = iq; irq_vector = 16'(iv); imem_wr = wr;
    @(negedge clk);
    br_valid = 0; br_taken = 0; irq_take = 0; imem_wr = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    checks++;
    if (fetch_addr !== '0 || dec_instr !== '0) begin
      fails++;
      $display("FAIL R1 reset actual %h/%h expected 0000/0000", fetch_addr, dec_instr);
    end
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R2"; idle(5);
    cur_req = "R3"; step(1, 0, 3, 40, 0, 0, 0); idle(2);
    cur_req = "R4"; step(1, 1, 8, 32, 0, 0, 0);
    cur_req = "R5"; idle(3);
    cur_req = "R6";
    for (int k = 0; k < 3; k++) begin
      step(1, 1, 8, 32, 0, 0, 0);
      checks++;
      if (dec_instr !== memw(16'd32, gen) || fetch_addr !== 16'd33) begin
        fails++;
        $display("FAIL R6 hit actual %h@%h expected %h@0021", dec_instr, fetch_addr, memw(16'd32, gen));
      end
      idle(2);
    end
    cur_req = "R7";
    step(1, 1, 50, 32, 0, 0, 0); idle(1);
    step(1, 1, 8, 32, 0, 0, 0);  idle(1);
    step(1, 1, 8, 60, 0, 0, 0);  idle(1);
    step(1, 1, 8, 60, 0, 0, 0);  idle(1);
    cur_req = "R8";
    step(0, 0, 0, 0, 0, 0, 1); idle(1);
    step(1, 1, 8, 60, 0, 0, 0);
    checks++;
    if (dec_instr !== '0) begin
      fails++; $display("FAIL R8 after write actual %h expected 0000", dec_instr);
    end
    idle(1);
    step(1, 1, 8, 60, 0, 0, 0); idle(1);
    step(1, 1, 70, 90, 0, 0, 1); idle(1);
    step(1, 1, 70, 90, 0, 0, 0); idle(1);
    step(1, 1, 70, 90, 0, 0, 0); idle(1);
    cur_req = "R9";
    step(0, 0, 0, 0, 1, 200, 0); idle(2);
    step(1, 1, 70, 90, 1, 300, 0); idle(1);
    step(1, 1, 70, 90, 0, 0, 0); idle(1);
    cur_req = "R10";
    step(1, 1, 120, 140, 0, 0, 0);
    step(1, 1, 120, 140, 0, 0, 0);
    idle(1);
    step(1, 1, 120, 140, 0, 0, 0); idle(3);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule